// File: doc/BRIEF.md
# Strobe-Controlled Host Register Bus Slave

This block sits between an external processor bus and a small internal register file. The processor uses an asynchronous handshake with an active-low chip select (`csN`), a read/write direction line (`rdWr`, high for read) and an active-low data strobe (`dsN`). The address is 8 bits. The data path is 16 bits, or 8 bits on data lines 7:0 when `byteMode` is set. All control inputs are brought into the internal clock domain through a synchronizer, and strobe edges are detected there.

The address can come from dedicated pins, or from a shared address/data bus. With separate buses (`addrMuxed` low), the address-latch strobe `ale` is tied high and the address is taken from the pins when the data strobe is asserted. With a shared bus (`addrMuxed` high), the address and the lane-enable bit are captured on the falling edge of `ale`. An active-low lane enable (`bleN`), together with address bit 0, picks a full-word access or one byte lane. The block then turns this into a per-byte write mask and per-lane output enables. A write is committed by a one-cycle pulse on the register-file side after the data strobe is released. On a read, the selected lanes are driven while the strobe is held.

Top module: `hbus_slave`

## Requirements
- R1: After reset, `dataOe` is 00 and `regWrEn` is low.
- R2: With separate buses, the address on `addrIn` when `dsN` falls with `csN` low selects the register, and `regAddr` equals address bits 7:1.
- R3: In shared-bus mode, `addrIn` and `bleN` are captured at the falling edge of `ale`. Later changes on those pins do not alter the access.
- R4: In 16-bit mode, the lane decode {`bleN`, addr bit 0} gives the following: 00 is a word access (mask 11, lines 15:8 and 7:0); 01 is a byte on lines 15:8 (mask 10); 10 is a byte on lines 7:0 (mask 01); 11 is no transfer.
- R5: In byte mode, write data comes from lines 7:0 and `bleN` is ignored. Address bit 0 low writes the upper byte (mask 10) and high writes the lower byte (mask 01), with the byte copied onto both halves of `regWrData`.
- R6: A write produces exactly one single-cycle `regWrEn` pulse after `dsN` is deasserted. It carries the data last present while the strobe was asserted.
- R7: `dataOe` is non-zero only while `csN` is low, `rdWr` is high and `dsN` is low (seen through the synchronizer). It drives `regRdData` on the decoded lanes and returns to 00 after `dsN` rises.
- R8: A read in byte mode drives only lines 7:0 (`dataOe` = 01). These carry register bits 15:8 when address bit 0 is low and bits 7:0 when it is high.
- R9: With `csN` held low, each new assertion of `dsN` is a separate cycle.
- R10: The no-transfer code produces no write pulse and no read drive, and the following cycle works normally.
- R11: A strobe given while `csN` is high is ignored: no write pulse and no read drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| byteMode | input | 1 | 1 = 8-bit bus on lines 7:0 |
| addrMuxed | input | 1 | 1 = address captured by `ale` falling edge |
| csN | input | 1 | Chip select, active low |
| rdWr | input | 1 | Direction: 1 read, 0 write |
| dsN | input | 1 | Data strobe, active low |
| ale | input | 1 | Address latch strobe (tied high with separate buses) |
| bleN | input | 1 | Lane enable, active low |
| addrIn | input | 8 | Address pins |
| dataIn | input | 16 | Data bus input |
| dataOut | output | 16 | Data bus output value |
| dataOe | output | 2 | Per-byte output enable (bit 1 = lines 15:8) |
| regAddr | output | 7 | Word index into the register file |
| regWrEn | output | 1 | Single-cycle write pulse |
| regWrMask | output | 2 | Byte write mask (bit 1 = bits 15:8) |
| regWrData | output | 16 | Write data to the register file |
| regRdData | input | 16 | Read data from the register file |

## Verification
All four lane codes are driven in 16-bit mode, both as writes and as reads, which separates word, upper-byte, lower-byte and no-transfer steering. The same writes are repeated in shared-bus mode, with the address and lane pins scrambled after `ale` falls, so that address capture at the latch edge is distinguished from sampling at the strobe. Byte-mode accesses with the lane enable set opposite to what 16-bit mode would need show that the lane input is ignored and that the byte is placed by address bit 0. Back-to-back strobes under a held chip select, and strobes with the chip select released, separate a new cycle from a rejected one. Write data is changed immediately after the strobe rises, so any write that takes late data is caught.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic cycStart;  // strobe fell with chip select active: latch cycle address
    logic aleFall;   // latch-strobe falling edge in shared-bus mode
    logic dsActive;  // synchronized strobe currently asserted
    logic rdDrive;   // drive read data onto the decoded lanes
  } hbusStrbT;

  // Lane selection, bit 1 = upper byte, bit 0 = lower byte
  typedef enum logic [1:0] {
    LANE_NONE = 2'b00,
    LANE_LOW  = 2'b01,
    LANE_HIGH = 2'b10,
    LANE_BOTH = 2'b11
  } laneT;

endpackage

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
  import hbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     addrMuxed,
  input  logic     csN,
  input  logic     rdWr,
  input  logic     dsN,
  input  logic     ale,
  input  logic     laneNone,
  output hbusStrbT strb,
  output logic     wrPulse
);

  localparam int NSIG = 4;

  logic [SYNC_STAGES-1:0][NSIG-1:0] syncChain;
  logic [NSIG-1:0] syncOut;
  logic csAct, rdSel, dsLow, aleHigh;
  logic dsLowPrev, aleHighPrev;
  logic cycOpen, cycRead;
  logic dsFall, dsRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '1;
    end else begin
      for (int i = SYNC_STAGES - 1; i > 0; i--) syncChain[i] <= syncChain[i-1];
      syncChain[0] <= {csN, rdWr, dsN, ale};
    end
  end

  assign syncOut = syncChain[SYNC_STAGES-1];
  assign csAct   = ~syncOut[3];
  assign rdSel   = syncOut[2];
  assign dsLow   = ~syncOut[1];
  assign aleHigh = syncOut[0];

  assign dsFall = dsLow & ~dsLowPrev;
  assign dsRise = ~dsLow & dsLowPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dsLowPrev   <= 1'b0;
      aleHighPrev <= 1'b1;
      cycOpen     <= 1'b0;
      cycRead     <= 1'b0;
    end else begin
      dsLowPrev   <= dsLow;
      aleHighPrev <= aleHigh;
      if (dsFall && csAct) begin
        cycOpen <= 1'b1;
        cycRead <= rdSel;
      end else if (dsRise) begin
        cycOpen <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.cycStart = dsFall & csAct;
    strb.aleFall  = aleHighPrev & ~aleHigh & addrMuxed;
    strb.dsActive = dsLow;
    strb.rdDrive  = cycOpen & cycRead & dsLow & csAct & ~laneNone;
  end

  assign wrPulse = dsRise & cycOpen & ~cycRead & ~laneNone;

endmodule

// File: rtl/hbus_dp.sv
module hbus_dp
  import hbus_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteMode,
  input  logic              addrMuxed,
  input  hbusStrbT          strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              bleN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] regRdData,
  output logic              laneNone,
  output logic [ADDR_W-2:0] regAddr,
  output logic [1:0]        regWrMask,
  output logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] dataOut,
  output logic [1:0]        dataOe
);

  localparam int LANES = DATA_W / 8;
  // Address pipe is one stage deeper so it lines up with the last sample
  // taken before a strobe edge was seen.
  localparam int APIPE = SYNC_STAGES + 1;

  logic [APIPE-1:0][ADDR_W:0]       addrPipe;
  logic [SYNC_STAGES-1:0][DATA_W-1:0] dataPipe;
  logic [ADDR_W:0] aleLatch;
  logic [ADDR_W:0] cycLatch;
  logic [DATA_W-1:0] wrData;
  laneT lane;
  logic addrLsb, cycBle;
  logic [1:0] oeLanes;
  logic [7:0] byteSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrPipe <= '0;
      dataPipe <= '0;
      aleLatch <= '0;
      cycLatch <= {1'b1, {ADDR_W{1'b0}}};
      wrData   <= '0;
    end else begin
      for (int i = APIPE - 1; i > 0; i--) addrPipe[i] <= addrPipe[i-1];
      addrPipe[0] <= {bleN, addrIn};
      for (int i = SYNC_STAGES - 1; i > 0; i--) dataPipe[i] <= dataPipe[i-1];
      dataPipe[0] <= dataIn;
      if (strb.aleFall) aleLatch <= addrPipe[APIPE-1];
      if (strb.cycStart) cycLatch <= addrMuxed ? aleLatch : addrPipe[APIPE-1];
      if (strb.dsActive) wrData <= dataPipe[SYNC_STAGES-1];
    end
  end

  assign addrLsb = cycLatch[0];
  assign cycBle  = cycLatch[ADDR_W];
  assign regAddr = cycLatch[ADDR_W-1:1];

  always_comb begin
    if (byteMode) begin
      lane = addrLsb ? LANE_LOW : LANE_HIGH;
    end else begin
      unique case ({cycBle, addrLsb})
        2'b00:   lane = LANE_BOTH;
        2'b01:   lane = LANE_HIGH;
        2'b10:   lane = LANE_LOW;
        default: lane = LANE_NONE;
      endcase
    end
  end

  assign laneNone  = (lane == LANE_NONE);
  assign regWrMask = lane;
  assign oeLanes   = byteMode ? 2'b01 : lane;
  assign dataOe    = strb.rdDrive ? oeLanes : 2'b00;
  assign byteSel   = addrLsb ? regRdData[7:0] : regRdData[15:8];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign regWrData[g*8 +: 8] = byteMode ? wrData[7:0] : wrData[g*8 +: 8];
    if (g == 0) begin : gLow
      assign dataOut[7:0] = byteMode ? byteSel : regRdData[7:0];
    end else begin : gUp
      assign dataOut[g*8 +: 8] = regRdData[g*8 +: 8];
    end
  end

endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
  import hbus_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteMode,
  input  logic              addrMuxed,
  input  logic              csN,
  input  logic              rdWr,
  input  logic              dsN,
  input  logic              ale,
  input  logic              bleN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [1:0]        dataOe,
  output logic [ADDR_W-2:0] regAddr,
  output logic              regWrEn,
  output logic [1:0]        regWrMask,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData
);

  hbusStrbT strb;
  logic laneNone;

  hbus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .addrMuxed(addrMuxed),
    .csN(csN), .rdWr(rdWr), .dsN(dsN), .ale(ale),
    .laneNone(laneNone), .strb(strb), .wrPulse(regWrEn)
  );

  hbus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .byteMode(byteMode), .addrMuxed(addrMuxed),
    .strb(strb), .addrIn(addrIn), .bleN(bleN), .dataIn(dataIn),
    .regRdData(regRdData), .laneNone(laneNone), .regAddr(regAddr),
    .regWrMask(regWrMask), .regWrData(regWrData), .dataOut(dataOut),
    .dataOe(dataOe)
  );

endmodule

// File: rtl/hbus_checker.sv
module hbus_checker #(
  parameter int SYNC = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       byteMode,
  input logic       csN,
  input logic       rdWr,
  input logic       dsN,
  input logic [1:0] dataOe,
  input logic       regWrEn,
  input logic [1:0] regWrMask
);

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (dataOe == 2'b00 && !regWrEn));

  assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  assert_wr_after_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $past(dsN, SYNC));

  assert_oe_needs_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe != 2'b00) |-> (!$past(dsN, SYNC) && !$past(csN, SYNC) && $past(rdWr, SYNC)));

  assert_no_drive_on_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (dataOe == 2'b00));

  assert_byte_lane_R8: assert property (@(posedge clk) disable iff (!rstN)
    (byteMode && dataOe != 2'b00) |-> (dataOe == 2'b01));

  assert_wr_has_lane_R10: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regWrMask != 2'b00));

endmodule

bind hbus_slave hbus_checker #(.SYNC(SYNC_STAGES)) uChk (
  .clk(clk), .rstN(rstN), .byteMode(byteMode), .csN(csN), .rdWr(rdWr),
  .dsN(dsN), .dataOe(dataOe), .regWrEn(regWrEn), .regWrMask(regWrMask)
);

// File: tb/hbus_slave_test.sv
module hbus_slave_test;

  typedef struct packed {
    logic [6:0]  addr;
    logic [1:0]  mask;
    logic [15:0] data;
  } wrItemT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteMode = 1'b0, addrMuxed = 1'b0;
  logic csN = 1'b1, rdWr = 1'b1, dsN = 1'b1, ale = 1'b1, bleN = 1'b1;
  logic [7:0]  addrIn = 8'h00;
  logic [15:0] dataIn = 16'h0000;
  logic [15:0] dataOut, regWrData, regRdData;
  logic [1:0]  dataOe, regWrMask;
  logic [6:0]  regAddr;
  logic        regWrEn;

  int checks = 0, fails = 0, pulses = 0;
  wrItemT expQ[$];

  always #10 clk = ~clk;

  function automatic logic [15:0] rdModel(input logic [6:0] w);
    return {1'b1, w, 8'h3C ^ {1'b0, w}};
  endfunction

  assign regRdData = rdModel(regAddr);

  hbus_slave uut (
    .clk(clk), .rstN(rstN), .byteMode(byteMode), .addrMuxed(addrMuxed),
    .csN(csN), .rdWr(rdWr), .dsN(dsN), .ale(ale), .bleN(bleN),
    .addrIn(addrIn), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrMask(regWrMask),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Lane code expected by the requirements (R4, R5)
  function automatic logic [1:0] expLane(input logic [7:0] a, input logic ble);
    if (byteMode) return a[0] ? 2'b01 : 2'b10;
    case ({ble, a[0]})
      2'b00:   return 2'b11;
      2'b01:   return 2'b10;
      2'b10:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  // Scoreboard monitor: compares each write pulse against the queue (R6)
  always @(negedge clk) begin
    if (rstN && regWrEn) begin
      wrItemT e;
      pulses++;
      if (expQ.size() == 0) begin
        check(1'b0, "R10/R11 unexpected write pulse", {14'd0, regWrMask, regWrData}, 32'd0);
      end else begin
        e = expQ.pop_front();
        check(regAddr == e.addr, "R2/R3 write address", {25'd0, regAddr}, {25'd0, e.addr});
        check(regWrMask == e.mask, "R4/R5 write mask", {30'd0, regWrMask}, {30'd0, e.mask});
        check(((regWrData ^ e.data) & {{8{e.mask[1]}}, {8{e.mask[0]}}}) == 16'h0,
              "R6 write data", {16'd0, regWrData}, {16'd0, e.data});
      end
    end
  end

  task automatic setupAddr(input logic [7:0] a, input logic ble);
    ale = 1'b1; addrIn = a; bleN = ble;
    if (addrMuxed) begin
      step(3);
      ale = 1'b0;
      step(1);
      addrIn = ~a; bleN = ~ble;  // scrambled after latch edge (R3)
      step(2);
    end else begin
      step(1);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic ble, input logic [15:0] d,
                         input logic sel, input logic release_cs);
    logic [1:0] m;
    wrItemT it;
    setupAddr(a, ble);
    csN = ~sel; rdWr = 1'b0;
    step(1);
    dsN = 1'b0; dataIn = 16'hDEAD;
    step(2);
    dataIn = d;
    step(4);
    m = expLane(a, ble);
    if (sel && m != 2'b00) begin
      it.addr = a[7:1]; it.mask = m;
      it.data = byteMode ? {d[7:0], d[7:0]} : d;
      expQ.push_back(it);
    end
    dsN = 1'b1; dataIn = 16'hBEEF;  // changed at once: late data must not land (R6)
    step(6);
    if (release_cs) begin csN = 1'b1; step(2); end
  endtask

  task automatic doRead(input logic [7:0] a, input logic ble, input logic sel, input string req);
    logic [1:0] m;
    logic [15:0] mdl;
    m = sel ? (byteMode ? 2'b01 : expLane(a, ble)) : 2'b00;
    mdl = rdModel(a[7:1]);
    setupAddr(a, ble);
    csN = ~sel; rdWr = 1'b1;
    step(1);
    dsN = 1'b0;
    step(5);
    @(negedge clk);
    check(dataOe == m, {req, " read lanes"}, {30'd0, dataOe}, {30'd0, m});
    if (byteMode) begin
      if (m != 2'b00)
        check(dataOut[7:0] == (a[0] ? mdl[7:0] : mdl[15:8]), "R8 byte read data",
              {24'd0, dataOut[7:0]}, {24'd0, (a[0] ? mdl[7:0] : mdl[15:8])});
    end else if (m != 2'b00) begin
      check(((dataOut ^ mdl) & {{8{m[1]}}, {8{m[0]}}}) == 16'h0, "R7 read data",
            {16'd0, dataOut}, {16'd0, mdl});
    end
    step(1);
    dsN = 1'b1;
    step(4);
    @(negedge clk);
    check(dataOe == 2'b00, "R7 release after strobe", {30'd0, dataOe}, 32'd0);
    step(1);
    csN = 1'b1; rdWr = 1'b1;
    step(2);
  endtask

  initial begin
    int p0;
    step(5);
    @(negedge clk);
    check(dataOe == 2'b00 && regWrEn == 1'b0, "R1 reset state", {29'd0, regWrEn, dataOe}, 32'd0);
    rstN = 1'b1;
    step(3);

    // 16-bit, separate buses: all four lane codes (R2, R4, R10)
    doWrite(8'h10, 1'b0, 16'h1234, 1'b1, 1'b1);
    doWrite(8'h21, 1'b0, 16'hA5C3, 1'b1, 1'b1);
    doWrite(8'h32, 1'b1, 16'h7E81, 1'b1, 1'b1);
    p0 = pulses;
    doWrite(8'h43, 1'b1, 16'hFFFF, 1'b1, 1'b1);
    check(pulses == p0, "R10 no-transfer write", pulses, p0);
    doRead(8'h10, 1'b0, 1'b1, "R4 word");
    doRead(8'h21, 1'b0, 1'b1, "R4 upper");
    doRead(8'h32, 1'b1, 1'b1, "R4 lower");
    doRead(8'h43, 1'b1, 1'b1, "R10 none");
    doWrite(8'h44, 1'b0, 16'h0F0F, 1'b1, 1'b1);  // R10: cycle after none works

    // Back-to-back under held chip select (R9)
    p0 = pulses;
    doWrite(8'h54, 1'b0, 16'h5555, 1'b1, 1'b0);
    doWrite(8'h66, 1'b0, 16'h6666, 1'b1, 1'b0);
    doWrite(8'h67, 1'b0, 16'h7777, 1'b1, 1'b1);
    check(pulses == p0 + 3, "R9 back-to-back cycles", pulses, p0 + 3);

    // Chip select released: ignored (R11)
    p0 = pulses;
    doWrite(8'h12, 1'b0, 16'h9999, 1'b0, 1'b1);
    check(pulses == p0, "R11 write without select", pulses, p0);
    doRead(8'h12, 1'b0, 1'b0, "R11 no select");

    // Shared bus: address latched at ale fall (R3)
    addrMuxed = 1'b1;
    step(2);
    doWrite(8'h8A, 1'b0, 16'hC0DE, 1'b1, 1'b1);
    doWrite(8'h9B, 1'b0, 16'hB00B, 1'b1, 1'b1);
    doWrite(8'hAC, 1'b1, 16'h00F1, 1'b1, 1'b1);
    doRead(8'hB6, 1'b0, 1'b1, "R3 shared word");
    doRead(8'hB7, 1'b0, 1'b1, "R3 shared upper");
    ale = 1'b1;
    addrMuxed = 1'b0;

    // Byte mode, lane enable set opposite (R5, R8)
    byteMode = 1'b1;
    step(2);
    doWrite(8'h70, 1'b1, 16'h33C4, 1'b1, 1'b1);
    doWrite(8'h71, 1'b0, 16'h4422, 1'b1, 1'b1);
    doRead(8'h70, 1'b1, 1'b1, "R8 even byte");
    doRead(8'h71, 1'b1, 1'b1, "R8 odd byte");
    byteMode = 1'b0;

    step(4);
    check(expQ.size() == 0, "R6 all expected writes seen", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule